// File: doc/BRIEF.md
# Predicated Vector Exponent Extractor

This block takes a packed vector of IEEE-754 values and returns, for every lane, the unbiased base-2 exponent of that lane as a signed integer. The integer has the same width as the lane. A 2-bit size code picks the lane format: half, single or double precision. Special inputs map to fixed codes. Infinity gives the top of the signed range. NaN and zero give the bottom of the range. A subnormal is normalised with a leading-zero count over its fraction, so no floating-point datapath is needed.

A byte-granular write mask governs which lanes are updated. A lane whose mask bit is clear passes the previous destination value through unchanged. The whole vector is evaluated in one combinational pass and then registered. A result appears one cycle after the input strobe. An unsupported size code raises a flag and leaves every lane untouched.

Top module: `fp_exp_extract`

## Requirements
- R1: Size code 1 selects 16-bit lanes (5-bit exponent at bits 14:10, 10-bit fraction). Code 2 selects 32-bit lanes (8-bit exponent at bits 30:23, 23-bit fraction). Code 3 selects 64-bit lanes (11-bit exponent at bits 62:52, 52-bit fraction). Each of these codes clears `illegal_size`.
- R2: Size code 0 sets `illegal_size` and returns `old_vec` unchanged in every lane.
- R3: A lane whose exponent field is neither all zeros nor all ones yields that field minus the bias. The bias is 15, 127 or 1023 for 16-, 32- or 64-bit lanes.
- R4: An infinity of either sign yields the largest positive signed integer of the lane width (for example 16'h7FFF).
- R5: A NaN (quiet or signalling) or a zero of either sign yields the most negative signed integer of the lane width (for example 16'h8000).
- R6: A nonzero subnormal yields −bias − L, where L is the number of leading zeros in the fraction field. For 16-bit lanes, fraction 0x200 gives −15 and fraction 0x001 gives −24 (16'hFFE8).
- R7: Mask bit k belongs to byte k of the vector. A lane is written when the mask bit of its lowest byte is set. Otherwise the lane keeps its `old_vec` value.
- R8: The sign bit never changes the result of a normal or subnormal lane.
- R9: `out_valid` is `in_valid` delayed by one clock. `out_vec` and `illegal_size` hold the result of the input accepted on that previous edge.
- R10: While `rst` is high, `out_valid`, `illegal_size` and `out_vec` clear to zero on the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe; the inputs are captured on this edge |
| size_code | input | 2 | Lane size: 1 = 16-bit, 2 = 32-bit, 3 = 64-bit, 0 = illegal |
| src_vec | input | VEC_W | Packed floating-point source lanes |
| old_vec | input | VEC_W | Previous destination contents |
| pred | input | VEC_W/8 | Per-byte write mask |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_vec | output | VEC_W | Merged exponent result |
| illegal_size | output | 1 | Set for a result produced with size code 0 |

## Verification
Every result comes out of one register stage, so `out_vec`, `illegal_size` and `out_valid` are due exactly one rising edge after the cycle in which `in_valid` is held high. The bench drives its inputs on the falling edge and samples one time unit after the next rising edge. It then drops `in_valid` and checks that `out_valid` falls on the following edge. The expected vectors come from a bench model of the exponent rules and the merge rule, applied lane by lane at all three sizes.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  typedef enum logic [1:0] {
    SZ_BAD  = 2'd0,
    SZ_HALF = 2'd1,
    SZ_SNGL = 2'd2,
    SZ_DBL  = 2'd3
  } size_e;

  localparam int unsigned H_EW = 5;
  localparam int unsigned H_FW = 10;
  localparam int unsigned S_EW = 8;
  localparam int unsigned S_FW = 23;
  localparam int unsigned D_EW = 11;
  localparam int unsigned D_FW = 52;
endpackage

// File: rtl/fpx_lzc.sv
module fpx_lzc #(
  parameter int unsigned W  = 10,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  val,
  output logic [CW-1:0] zeros
);
  always_comb begin
    zeros = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (val[i]) zeros = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fpx_lane_logb.sv
module fpx_lane_logb #(
  parameter int unsigned EW = 5,
  parameter int unsigned FW = 10,
  localparam int unsigned W  = 1 + EW + FW,
  localparam int unsigned CW = $clog2(FW + 1)
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  localparam logic [W-1:0] BIAS  = W'((64'd1 << (EW - 1)) - 64'd1);
  localparam logic [W-1:0] TOP   = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] FLOOR = {1'b1, {(W-1){1'b0}}};

  logic [EW-1:0] expf;
  logic [FW-1:0] frac;
  logic [CW-1:0] lz;
  logic          sign_unused;

  assign expf        = x[W-2 -: EW];
  assign frac        = x[FW-1:0];
  assign sign_unused = x[W-1];

  fpx_lzc #(.W(FW)) u_lzc (.val(frac), .zeros(lz));

  always_comb begin
    if (&expf) begin
      y = (frac == '0) ? TOP : FLOOR;
    end else if (expf == '0) begin
      if (frac == '0) y = FLOOR;
      else            y = W'(0) - BIAS - W'(lz);
    end else begin
      y = W'(expf) - BIAS;
    end
  end
endmodule

// File: rtl/fpx_lane_bank.sv
module fpx_lane_bank #(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned EW    = 5,
  parameter int unsigned FW    = 10,
  localparam int unsigned W     = 1 + EW + FW,
  localparam int unsigned LANES = VEC_W / W,
  localparam int unsigned LB    = W / 8
) (
  input  logic [VEC_W-1:0]   src,
  input  logic [VEC_W-1:0]   old,
  input  logic [VEC_W/8-1:0] pred,
  output logic [VEC_W-1:0]   merged
);
  logic pred_unused;
  assign pred_unused = ^pred;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [W-1:0] res;
    fpx_lane_logb #(.EW(EW), .FW(FW)) u_lane (
      .x(src[g*W +: W]),
      .y(res)
    );
    assign merged[g*W +: W] = pred[g*LB] ? res : old[g*W +: W];
  end
endmodule

// File: rtl/fp_exp_extract.sv
module fp_exp_extract #(
  parameter int unsigned VEC_W = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [1:0]         size_code,
  input  logic [VEC_W-1:0]   src_vec,
  input  logic [VEC_W-1:0]   old_vec,
  input  logic [VEC_W/8-1:0] pred,
  output logic               out_valid,
  output logic [VEC_W-1:0]   out_vec,
  output logic               illegal_size
);
  import fpx_pkg::*;

  logic [VEC_W-1:0] m_half, m_sngl, m_dbl, nxt_vec;
  logic             nxt_bad;

  fpx_lane_bank #(.VEC_W(VEC_W), .EW(H_EW), .FW(H_FW)) u_bank_h (
    .src(src_vec), .old(old_vec), .pred(pred), .merged(m_half));
  fpx_lane_bank #(.VEC_W(VEC_W), .EW(S_EW), .FW(S_FW)) u_bank_s (
    .src(src_vec), .old(old_vec), .pred(pred), .merged(m_sngl));
  fpx_lane_bank #(.VEC_W(VEC_W), .EW(D_EW), .FW(D_FW)) u_bank_d (
    .src(src_vec), .old(old_vec), .pred(pred), .merged(m_dbl));

  always_comb begin
    nxt_bad = 1'b0;
    case (size_e'(size_code))
      SZ_HALF: nxt_vec = m_half;
      SZ_SNGL: nxt_vec = m_sngl;
      SZ_DBL:  nxt_vec = m_dbl;
      default: begin
        nxt_vec = old_vec;
        nxt_bad = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      illegal_size <= 1'b0;
      out_vec      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_vec      <= nxt_vec;
        illegal_size <= nxt_bad;
      end
    end
  end
endmodule

// File: rtl/fpx_checker.sv
module fpx_checker #(
  parameter int unsigned VEC_W = 128
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [1:0]         size_code,
  input logic [VEC_W-1:0]   old_vec,
  input logic [VEC_W/8-1:0] pred,
  input logic               out_valid,
  input logic [VEC_W-1:0]   out_vec,
  input logic               illegal_size
);
  logic pred_unused;
  assign pred_unused = ^pred[VEC_W/8-1:1];

  a_r9_valid_rise: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r9_valid_fall: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r2_bad_size: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_code == 2'd0) |=> (illegal_size && out_vec == $past(old_vec)));
  a_r1_good_size: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_code != 2'd0) |=> !illegal_size);
  a_r7_lane0_kept: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !pred[0]) |=> (out_vec[15:0] == $past(old_vec[15:0])));
  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && !illegal_size && out_vec == '0));
endmodule

bind fp_exp_extract fpx_checker #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .size_code(size_code),
  .old_vec(old_vec), .pred(pred), .out_valid(out_valid),
  .out_vec(out_vec), .illegal_size(illegal_size)
);

// File: tb/fp_exp_extract_tb.sv
module fp_exp_extract_tb;
  localparam int VW = 128;
  localparam int PW = VW / 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [1:0]    size_code = 2'd0;
  logic [VW-1:0] src_vec = '0, old_vec = '0;
  logic [PW-1:0] pred = '0;
  logic          out_valid, illegal_size;
  logic [VW-1:0] out_vec;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fp_exp_extract #(.VEC_W(VW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .size_code(size_code),
    .src_vec(src_vec), .old_vec(old_vec), .pred(pred),
    .out_valid(out_valid), .out_vec(out_vec), .illegal_size(illegal_size));

  function automatic int lw(int sz);
    return 16 << (sz - 1);
  endfunction

  function automatic logic [63:0] wmask(int w);
    return (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [63:0] ref_lane(logic [63:0] x, int sz);
    int w, ew, fw, lz;
    longint bias, e, r;
    logic [63:0] f;
    w  = lw(sz);
    ew = (sz == 1) ? 5 : (sz == 2) ? 8 : 11;
    fw = w - 1 - ew;
    bias = (longint'(1) << (ew - 1)) - 1;
    e = longint'((x >> fw) & ((64'd1 << ew) - 64'd1));
    f = x & ((64'd1 << fw) - 64'd1);
    if (e == (longint'(1) << ew) - 1) begin
      if (f == 0) return wmask(w) >> 1;
      return 64'd1 << (w - 1);
    end
    if (e == 0) begin
      if (f == 0) return 64'd1 << (w - 1);
      lz = 0;
      for (int b = fw - 1; b >= 0; b--) begin
        if (f[b]) break;
        lz++;
      end
      r = -bias - lz;
      return 64'(r) & wmask(w);
    end
    r = e - bias;
    return 64'(r) & wmask(w);
  endfunction

  function automatic logic [VW-1:0] ref_vec(int sz, logic [VW-1:0] s,
                                            logic [VW-1:0] o, logic [PW-1:0] p);
    logic [VW-1:0] res;
    logic [VW-1:0] m;
    logic [63:0]   lane;
    int w;
    res = o;
    if (sz == 0) return res;
    w = lw(sz);
    for (int i = 0; i < VW / w; i++) begin
      if (p[i * w / 8]) begin
        lane = ref_lane(64'((s >> (i * w)) & VW'(wmask(w))), sz);
        m = VW'(wmask(w)) << (i * w);
        res = (res & ~m) | (VW'(lane) << (i * w));
      end
    end
    return res;
  endfunction

  function automatic logic [VW-1:0] rep(logic [63:0] x, int sz);
    logic [VW-1:0] v;
    int w;
    v = '0;
    w = lw(sz);
    for (int i = 0; i < VW / w; i++) v |= VW'(x & wmask(w)) << (i * w);
    return v;
  endfunction

  task automatic chk(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(int sz, logic [VW-1:0] s, logic [VW-1:0] o,
                       logic [PW-1:0] p, string tag);
    @(negedge clk);
    size_code = 2'(sz);
    src_vec   = s;
    old_vec   = o;
    pred      = p;
    in_valid  = 1'b1;
    @(posedge clk);
    #1;
    chk({tag, " data"}, out_vec, ref_vec(sz, s, o, p));
    chk({tag, " flag R1/R2"}, VW'(illegal_size), VW'(sz == 0));
    chk("R9 valid high", VW'(out_valid), VW'(1));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic corner(int sz, logic [63:0] x, string tag);
    apply(sz, rep(x, sz), {VW/32{32'hA5A5_5A5A}}, {PW{1'b1}}, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] s, o;
    logic [PW-1:0] p;
    void'($urandom(32'd20240517));
    old_vec = '1;
    in_valid = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset vec", out_vec, '0);
    chk("R10 reset flags", VW'({out_valid, illegal_size}), '0);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b0;

    // R3 normals, with literal expectations too
    corner(1, 64'h3C00, "R3 half 1.0");
    chk("R3 half 1.0 literal", out_vec, '0);
    corner(1, 64'h0400, "R3 half min normal");
    corner(1, 64'h7BFF, "R3 half max normal");
    corner(2, 64'h0080_0000, "R3 single min normal");
    corner(2, 64'h7F7F_FFFF, "R3 single max normal");
    chk("R3 single 127 literal", out_vec, {VW/32{32'h0000_007F}});
    corner(3, 64'h0010_0000_0000_0000, "R3 double min normal");
    corner(3, 64'h7FEF_FFFF_FFFF_FFFF, "R3 double max normal");
    // R4 infinities
    corner(1, 64'h7C00, "R4 half +inf");
    chk("R4 half +inf literal", out_vec, {VW/16{16'h7FFF}});
    corner(1, 64'hFC00, "R4 half -inf");
    corner(2, 64'hFF80_0000, "R4 single -inf");
    corner(3, 64'h7FF0_0000_0000_0000, "R4 double +inf");
    // R5 NaN and zero
    corner(1, 64'h7E00, "R5 half qnan");
    corner(1, 64'h7C01, "R5 half snan");
    corner(1, 64'h8000, "R5 half -0");
    chk("R5 half -0 literal", out_vec, {VW/16{16'h8000}});
    corner(2, 64'h0000_0000, "R5 single +0");
    corner(2, 64'h7F80_0001, "R5 single snan");
    corner(3, 64'h7FF8_0000_0000_0000, "R5 double qnan");
    corner(3, 64'h8000_0000_0000_0000, "R5 double -0");
    // R6 subnormals
    corner(1, 64'h0001, "R6 half min sub");
    chk("R6 half min sub literal", out_vec, {VW/16{16'hFFE8}});
    corner(1, 64'h03FF, "R6 half max sub");
    chk("R6 half max sub literal", out_vec, {VW/16{16'hFFF1}});
    corner(2, 64'h0000_0001, "R6 single min sub");
    corner(2, 64'h007F_FFFF, "R6 single max sub");
    corner(3, 64'h0000_0000_0000_0001, "R6 double min sub");
    chk("R6 double min sub literal", out_vec, {VW/64{64'hFFFF_FFFF_FFFF_FBCE}});
    corner(3, 64'h000F_FFFF_FFFF_FFFF, "R6 double max sub");
    // R8 sign independence
    corner(2, 64'hBFC0_0000, "R8 single -1.5");
    chk("R8 sign ignored normal", out_vec, {VW/32{32'h0}});
    corner(1, 64'h8001, "R8 half -min sub");
    chk("R8 sign ignored subnormal", out_vec, {VW/16{16'hFFE8}});
    // R1 same source at each size
    s = {VW/32{32'h4000_4000}};
    apply(1, s, '0, {PW{1'b1}}, "R1 size half");
    apply(2, s, '0, {PW{1'b1}}, "R1 size single");
    apply(3, s, '0, {PW{1'b1}}, "R1 size double");
    // R2 illegal size
    o = {VW/32{32'hDEAD_BEEF}};
    apply(0, s, o, {PW{1'b1}}, "R2 illegal size");
    chk("R2 old kept", out_vec, o);
    chk("R2 flag set", VW'(illegal_size), VW'(1));
    // R9 valid drops a cycle after strobe drops
    @(posedge clk);
    #1;
    chk("R9 valid low", VW'(out_valid), '0);
    // R7 predicate patterns
    o = {VW/32{32'h1234_5678}};
    apply(1, s, o, {PW/2{2'b10}}, "R7 half upper bytes only");
    chk("R7 half all lanes kept", out_vec, o);
    apply(2, s, o, {PW/4{4'b0001}}, "R7 single low byte");
    apply(3, s, o, {PW/8{8'b1111_1110}}, "R7 double low byte clear");
    chk("R7 double kept", out_vec, o);
    // random mix
    for (int it = 0; it < 400; it++) begin
      int sz;
      sz = int'($urandom % 4);
      for (int wd = 0; wd < VW / 32; wd++) begin
        logic [31:0] r;
        r = $urandom;
        case ($urandom % 4)
          0: r = r & 32'h83FF_83FF;
          1: r = r | 32'h7C00_7F80;
          default: ;
        endcase
        s[wd*32 +: 32] = r;
        o[wd*32 +: 32] = $urandom;
      end
      for (int b = 0; b < PW; b++) p[b] = 1'($urandom);
      apply(sz, s, o, p, "R7 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule